// File: doc/BRIEF.md
# Multiply-Add Invalid-Result Resolver

This block sits at the output of a single-precision multiply-add / multiply-subtract datapath. The arithmetic core computes `a*b + c` (or `c - a*b` in subtract mode) and reports whether the operation was invalid. This block takes that raw result together with the original operands. It then decides whether the raw result stands or is replaced by one of three fixed quiet-NaN codes, each of which names the cause of the invalid result.

Each operand is split into sign (bit 31), exponent (bits 30:23) and mantissa (bits 22:0). A denormal operand is flushed to a zero of the same sign. The operand is then classed as zero, finite, infinite or NaN. A priority resolver picks the cause. The chosen word and a status flag go to a one-entry output stage. That stage is a two-state machine: `ST_EMPTY` goes to `ST_FULL` on `in_valid`; `ST_FULL` stays in `ST_FULL` while `in_valid` stays high and returns to `ST_EMPTY` when it drops. The output is visible one cycle after the input strobe.

Top module: `madd_nan_resolver`

## Requirements
- R1: With `inv_flag` high, if any of the three operands is a NaN (exponent 0xFF, mantissa nonzero), the result is 0x7FC00000. This cause outranks every other.
- R2: With `inv_flag` high and no NaN operand, if one product operand is infinite (exponent 0xFF, mantissa zero) and the other is zero, in either order, the result is 0x7FC00002. This outranks R3.
- R3: With `inv_flag` high and neither R1 nor R2 applying, the result is 0x7FC00001 when three things hold: a product operand is infinite, the addend is infinite, and sign(a) XOR sign(b) XOR effective sign(c) is 1.
- R4: When `sub_mode` is 1, the effective sign of the addend is its sign bit inverted. When `sub_mode` is 0, it is the sign bit as given.
- R5: A denormal operand (exponent 0, mantissa nonzero) counts as a zero of its own sign for R2 and R3.
- R6: With `inv_flag` low, `raw_result` is passed out unchanged, whatever the operands hold.
- R7: With `inv_flag` high and none of R1 to R3 applying, `raw_result` is passed out unchanged.
- R8: `out_status` is 1 when `inv_flag` or `exc_flag` was high for the captured operation. It is 0 when both were low.
- R9: `out_valid` equals `in_valid` delayed by one clock. While `in_valid` is low, `out_result` and `out_status` hold their values.
- R10: Synchronous active-high `rst` clears `out_valid`, `out_result` and `out_status` to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input strobe; operands and flags are captured when it is high |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| op_c | input | 32 | Addend |
| raw_result | input | 32 | Result computed by the arithmetic core |
| inv_flag | input | 1 | Invalid-operation flag from the core |
| exc_flag | input | 1 | OR of the core's other exception flags |
| sub_mode | input | 1 | 1 selects multiply-subtract |
| out_valid | output | 1 | Output strobe, one cycle after `in_valid` |
| out_result | output | 32 | Final result word |
| out_status | output | 1 | Exception status of the captured operation |

## Verification
The only state is the output stage, so any fault in the state machine shows at the ports one edge after the input strobe. A wrong state shows as `out_valid` being out of step with `in_valid`. A bad load enable shows as a result changing while the strobe is low. Faults in classification or priority show as the wrong code, or as a leaked raw word, in the cycle after the operand is captured. The directed cases therefore pair causes that compete: NaN against infinity-times-zero, infinity-times-zero against opposing infinities, both subtract polarities, and denormals against true zeros.

// File: rtl/madd_nan_resolver_pkg.sv
package madd_nan_resolver_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO   = 2'd0,
        CLS_FINITE = 2'd1,
        CLS_INF    = 2'd2,
        CLS_NAN    = 2'd3
    } op_class_t;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_NAN_IN = 2'd1,
        CAUSE_MUL    = 2'd2,
        CAUSE_ADD    = 2'd3
    } cause_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_t;

endpackage

// File: rtl/fmr_classify.sv
module fmr_classify
    import madd_nan_resolver_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input  logic [WORD_W-1:0] op,
    output logic              sign,
    output op_class_t         cls
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    assign sign  = op[WORD_W-1];
    assign exp_f = op[WORD_W-2:MAN_W];
    assign man_f = op[MAN_W-1:0];

    // Denormals (exp zero, mantissa nonzero) collapse to zero of the same sign.
    always_comb begin
        if (exp_f == '0)
            cls = CLS_ZERO;
        else if (&exp_f)
            cls = (man_f == '0) ? CLS_INF : CLS_NAN;
        else
            cls = CLS_FINITE;
    end
endmodule

// File: rtl/fmr_cause.sv
module fmr_cause
    import madd_nan_resolver_pkg::*;
(
    input  logic      inv_flag,
    input  logic      sub_mode,
    input  logic      sign_a,
    input  logic      sign_b,
    input  logic      sign_c,
    input  op_class_t cls_a,
    input  op_class_t cls_b,
    input  op_class_t cls_c,
    output cause_t    cause
);
    logic any_nan;
    logic inf_times_zero;
    logic prod_inf;
    logic signs_oppose;

    assign any_nan        = (cls_a == CLS_NAN) || (cls_b == CLS_NAN) || (cls_c == CLS_NAN);
    assign inf_times_zero = ((cls_a == CLS_INF) && (cls_b == CLS_ZERO)) ||
                            ((cls_a == CLS_ZERO) && (cls_b == CLS_INF));
    assign prod_inf       = (cls_a == CLS_INF) || (cls_b == CLS_INF);
    assign signs_oppose   = sign_a ^ sign_b ^ (sign_c ^ sub_mode);

    // Fixed priority: NaN operand, then inf*0, then opposing infinities.
    always_comb begin
        cause = CAUSE_NONE;
        if (inv_flag) begin
            if (any_nan)
                cause = CAUSE_NAN_IN;
            else if (inf_times_zero)
                cause = CAUSE_MUL;
            else if (prod_inf && (cls_c == CLS_INF) && signs_oppose)
                cause = CAUSE_ADD;
        end
    end
endmodule

// File: rtl/fmr_out_stage.sv
module fmr_out_stage
    import madd_nan_resolver_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] nxt_result,
    input  logic              nxt_status,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic              out_status
);
    out_state_t state_q;
    out_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)  state_d = ST_FULL;
            ST_FULL:  if (!in_valid) state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_result <= '0;
            out_status <= 1'b0;
        end else if (in_valid) begin
            out_result <= nxt_result;
            out_status <= nxt_status;
        end
    end

    assign out_valid = (state_q == ST_FULL);
endmodule

// File: rtl/madd_nan_resolver.sv
module madd_nan_resolver
    import madd_nan_resolver_pkg::*;
#(
    parameter int EXP_W       = 8,
    parameter int MAN_W       = 23,
    parameter int PAYLOAD_ADD = 1,
    parameter int PAYLOAD_MUL = 2,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] op_c,
    input  logic [WORD_W-1:0] raw_result,
    input  logic              inv_flag,
    input  logic              exc_flag,
    input  logic              sub_mode,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic              out_status
);
    localparam int NUM_OPS = 3;
    localparam logic [WORD_W-1:0] QNAN_BASE = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] NAN_ADD   = QNAN_BASE | WORD_W'(PAYLOAD_ADD);
    localparam logic [WORD_W-1:0] NAN_MUL   = QNAN_BASE | WORD_W'(PAYLOAD_MUL);

    logic [WORD_W-1:0] ops [NUM_OPS];
    logic              signs [NUM_OPS];
    op_class_t         classes [NUM_OPS];
    cause_t            cause;
    logic [WORD_W-1:0] sel_result;

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign ops[2] = op_c;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
        fmr_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_cls (
            .op   (ops[g]),
            .sign (signs[g]),
            .cls  (classes[g])
        );
    end

    fmr_cause i_cause (
        .inv_flag (inv_flag),
        .sub_mode (sub_mode),
        .sign_a   (signs[0]),
        .sign_b   (signs[1]),
        .sign_c   (signs[2]),
        .cls_a    (classes[0]),
        .cls_b    (classes[1]),
        .cls_c    (classes[2]),
        .cause    (cause)
    );

    always_comb begin
        unique case (cause)
            CAUSE_NAN_IN: sel_result = QNAN_BASE;
            CAUSE_MUL:    sel_result = NAN_MUL;
            CAUSE_ADD:    sel_result = NAN_ADD;
            default:      sel_result = raw_result;
        endcase
    end

    fmr_out_stage #(.WORD_W(WORD_W)) i_out (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .nxt_result (sel_result),
        .nxt_status (inv_flag | exc_flag),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_status (out_status)
    );
endmodule

// File: rtl/madd_nan_resolver_chk.sv
module madd_nan_resolver_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic [31:0] op_c,
    input logic [31:0] raw_result,
    input logic        inv_flag,
    input logic        exc_flag,
    input logic        sub_mode,
    input logic        out_valid,
    input logic [31:0] out_result,
    input logic        out_status
);
    logic nan_seen;
    assign nan_seen = ((op_a[30:23] == 8'hFF) && (op_a[22:0] != 0)) ||
                      ((op_b[30:23] == 8'hFF) && (op_b[22:0] != 0)) ||
                      ((op_c[30:23] == 8'hFF) && (op_c[22:0] != 0));

    // R1
    nan_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && inv_flag && nan_seen) |=> (out_result == 32'h7FC00000));

    // R6
    pass_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !inv_flag) |=> (out_result == $past(raw_result)));

    // R8
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !inv_flag && !exc_flag) |=> !out_status);

    // R8
    status_set_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (inv_flag || exc_flag)) |=> out_status);

    // R9
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_status)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_status && (out_result == 32'h0)));
endmodule

bind madd_nan_resolver madd_nan_resolver_chk i_chk (.*);

// File: tb/test_madd_nan_resolver.sv
module test_madd_nan_resolver;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0, raw_result = '0;
    logic        inv_flag = 1'b0, exc_flag = 1'b0, sub_mode = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_status;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    localparam logic [31:0] PINF = 32'h7F800000, NINF = 32'hFF800000;
    localparam logic [31:0] ONE  = 32'h3F800000, PZ   = 32'h0, NZ = 32'h80000000;
    localparam logic [31:0] SNAN = 32'h7F800001, QNAN = 32'h7FC00000;
    localparam logic [31:0] PDEN = 32'h00000001, NDEN = 32'h80000001;
    localparam logic [31:0] RAW  = 32'h12345678;
    localparam logic [31:0] Q_ANY = 32'h7FC00000, Q_ADD = 32'h7FC00001, Q_MUL = 32'h7FC00002;

    always #2.5 clk = ~clk;

    madd_nan_resolver i_madd_nan_resolver (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .raw_result(raw_result),
        .inv_flag(inv_flag), .exc_flag(exc_flag), .sub_mode(sub_mode),
        .out_valid(out_valid), .out_result(out_result), .out_status(out_status)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one operation at a falling edge; it is captured at the next rising
    // edge and observed at the falling edge after that.
    task automatic run_op(string req, logic [31:0] a, logic [31:0] b, logic [31:0] c,
                          logic inv, logic exc, logic sub,
                          logic [31:0] exp_res, logic exp_stat);
        op_a = a; op_b = b; op_c = c; raw_result = RAW;
        inv_flag = inv; exc_flag = exc; sub_mode = sub; in_valid = 1'b1;
        @(negedge clk);
        check({req, " valid"}, {31'b0, out_valid}, 32'd1);
        check({req, " result"}, out_result, exp_res);
        check({req, " status"}, {31'b0, out_status}, {31'b0, exp_stat});
    endtask

    task automatic test_reset();
        check("R10 valid", {31'b0, out_valid}, 32'd0);
        check("R10 result", out_result, 32'd0);
        check("R10 status", {31'b0, out_status}, 32'd0);
    endtask

    task automatic test_passthrough();
        run_op("R6 clean", ONE, ONE, ONE, 1'b0, 1'b0, 1'b0, RAW, 1'b0);
        run_op("R6 nan ignored without flag", SNAN, PINF, PZ, 1'b0, 1'b0, 1'b0, RAW, 1'b0);
        run_op("R8 other exception", ONE, ONE, ONE, 1'b0, 1'b1, 1'b0, RAW, 1'b1);
    endtask

    task automatic test_nan_in();
        run_op("R1 a nan", SNAN, ONE, ONE, 1'b1, 1'b0, 1'b0, Q_ANY, 1'b1);
        run_op("R1 c nan", ONE, ONE, QNAN, 1'b1, 1'b0, 1'b0, Q_ANY, 1'b1);
        run_op("R1 over inf*0", PINF, SNAN | 32'h1, PZ, 1'b1, 1'b0, 1'b0, Q_ANY, 1'b1);
        run_op("R1 b nan with a zero", PZ, 32'hFFC00005, NINF, 1'b1, 1'b0, 1'b0, Q_ANY, 1'b1);
    endtask

    task automatic test_mul();
        run_op("R2 inf*0", PINF, PZ, ONE, 1'b1, 1'b0, 1'b0, Q_MUL, 1'b1);
        run_op("R2 0*inf", NZ, NINF, ONE, 1'b1, 1'b0, 1'b0, Q_MUL, 1'b1);
        run_op("R2 over add", PINF, PZ, NINF, 1'b1, 1'b0, 1'b0, Q_MUL, 1'b1);
        run_op("R5 inf*denormal", PINF, PDEN, ONE, 1'b1, 1'b0, 1'b0, Q_MUL, 1'b1);
        run_op("R5 neg denormal*inf", NDEN, NINF, ONE, 1'b1, 1'b0, 1'b0, Q_MUL, 1'b1);
    endtask

    task automatic test_add();
        run_op("R3 inf plus -inf", PINF, ONE, NINF, 1'b1, 1'b0, 1'b0, Q_ADD, 1'b1);
        run_op("R3 -inf product plus inf", ONE, NINF, PINF, 1'b1, 1'b0, 1'b0, Q_ADD, 1'b1);
        run_op("R4 sub same-signed inf", PINF, ONE, PINF, 1'b1, 1'b0, 1'b1, Q_ADD, 1'b1);
        run_op("R4 sub opposite inf no cause", PINF, ONE, NINF, 1'b1, 1'b0, 1'b1, RAW, 1'b1);
        run_op("R7 same-signed inf no cause", PINF, ONE, PINF, 1'b1, 1'b0, 1'b0, RAW, 1'b1);
        run_op("R7 finite only", ONE, ONE, ONE, 1'b1, 1'b0, 1'b0, RAW, 1'b1);
        run_op("R5 denormal addend is not inf", PINF, ONE, NDEN, 1'b1, 1'b0, 1'b0, RAW, 1'b1);
    endtask

    task automatic test_hold();
        run_op("R9 load", PINF, PZ, ONE, 1'b1, 1'b0, 1'b0, Q_MUL, 1'b1);
        in_valid = 1'b0;
        op_a = ONE; op_b = ONE; inv_flag = 1'b0; exc_flag = 1'b0; raw_result = 32'hDEADBEEF;
        @(negedge clk);
        check("R9 valid drops", {31'b0, out_valid}, 32'd0);
        check("R9 result held", out_result, Q_MUL);
        check("R9 status held", {31'b0, out_status}, 32'd1);
        @(negedge clk);
        check("R9 still held", out_result, Q_MUL);
    endtask

    task automatic test_reset_again();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        test_reset();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_passthrough();
        test_nan_in();
        test_mul();
        test_add();
        test_hold();
        test_reset_again();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule